// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a compact multicycle processor. Its only architectural data register is an accumulator, which no instruction names. Every instruction is one 16-bit word. The top three bits select one of seven operations and the low thirteen bits give a direct word address. Programs and data share a single 8K-word space. That space lives in an external synchronous single-port RAM, which the core drives through an address, a write strobe, write data and registered read data.

Each instruction passes through a fixed sequence of phases: instruction fetch, decode, an optional data-memory phase, and a commit phase. Memory-touching operations (load, add, store) take four clock cycles. Branch, call, return and stop take three. Subroutine linkage uses a small on-chip return-address stack rather than main memory.

The RAM answers every read after exactly one cycle and accepts every write at once. For this reason the memory side carries no valid/ready handshake and never applies back-pressure. The PC, accumulator, negative flag and halt indication are plain observation outputs.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and just after it is released, the PC is 0, the accumulator is 0, the negative flag is 0, halted is 0 and the core fetches from address 0.
- R2: Bits [15:13] of an instruction are the opcode and bits [12:0] are the operand address. The encodings are Call 000, Return 001, Add 010, Brn 011, Load 100, Store 101 and Stop 110.
- R3: Load places the word at the operand address in the accumulator. The negative flag becomes bit 15 of that word.
- R4: Add adds the word at the operand address to the accumulator modulo 2^16. The negative flag becomes bit 15 of the sum.
- R5: Store writes the accumulator to the operand address. The accumulator and flag are unchanged, and the write data equals the accumulator.
- R6: Brn jumps to the operand address when the negative flag is 1. Otherwise it continues at PC+1.
- R7: Call pushes PC+1 onto a 16-entry return stack and jumps to the operand address. Return pops the most recent entry into the PC. Calls nest in last-in-first-out order.
- R8: Stop raises halted at the end of its commit phase. From then until reset, halted stays 1, the PC stays at the Stop's address, the accumulator does not change and no memory write occurs.
- R9: Only Add and Load change the negative flag. All other instructions leave it unchanged.
- R10: Load, Add and Store complete in 4 cycles and the other instructions in 3. The PC and accumulator outputs change only at the cycle an instruction completes.
- R11: The PC increments modulo 2^13, so the instruction after address 0x1FFF is fetched from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 13 | RAM word address |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, one cycle after the address |
| pc_o | output | 13 | Program counter of the next instruction |
| acc_o | output | 16 | Accumulator |
| neg_o | output | 1 | Negative condition flag |
| halted_o | output | 1 | High once Stop has completed |

## Verification
The assertions check several properties on every cycle:
- The PC and accumulator move only in the cycle after a commit phase.
- Any accumulator change leaves the flag equal to its sign bit.
- Only a committed Add or Load alters the flag.
- Store data always equals the accumulator.
- The halted state is sticky, freezes the PC and accumulator, and issues no writes.

Only the bench's programs can show the rest:
- correct arithmetic and load values, including wrap-around sums;
- taken versus fallen-through branches;
- nested call and return order;
- exact cycle counts;
- PC wrap from the top of the address space.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_CALL  = 3'b000,
    OP_RET   = 3'b001,
    OP_ADD   = 3'b010,
    OP_BRN   = 3'b011,
    OP_LOAD  = 3'b100,
    OP_STORE = 3'b101,
    OP_STOP  = 3'b110,
    OP_RSVD  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_MEM,
    S_WB,
    S_HALT
  } phase_e;

  function automatic logic needs_mem(op_e op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  dec_op,    // opcode arriving from RAM during decode
  input  op_e  ir_op,     // opcode held in the instruction register
  output logic ir_en,
  output logic mem_phase,
  output logic wb_phase,
  output logic halted
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      S_FETCH:  phase_d = S_DECODE;
      S_DECODE: phase_d = needs_mem(dec_op) ? S_MEM : S_WB;
      S_MEM:    phase_d = S_WB;
      S_WB:     phase_d = (ir_op == OP_STOP) ? S_HALT : S_FETCH;
      S_HALT:   phase_d = S_HALT;
      default:  phase_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= S_FETCH;
    else        phase_q <= phase_d;
  end

  assign ir_en     = (phase_q == S_DECODE);
  assign mem_phase = (phase_q == S_MEM);
  assign wb_phase  = (phase_q == S_WB);
  assign halted    = (phase_q == S_HALT);
endmodule

// File: rtl/acc_rstack.sv
module acc_rstack #(
  parameter int DEPTH = 16,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] pop_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // sp names the next free slot; it starts one below the base and grows down
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_up;
  logic [W-1:0]     slot [DEPTH];

  assign sp_up = sp_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= PTR_W'(DEPTH - 1);
    else if (push) sp_q <= sp_q - 1'b1;
    else if (pop)  sp_q <= sp_up;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && sp_q == PTR_W'(g)) slot[g] <= push_data;
    end
  end

  assign pop_data = slot[sp_up];
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_en,
  input  logic              mem_phase,
  input  logic              wb_phase,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [ADDR_W-1:0] pop_addr,
  output logic              push,
  output logic              pop,
  output logic [ADDR_W-1:0] push_addr,
  output op_e               ir_op,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] acc,
  output logic              neg
);
  logic [DATA_W-1:0] ir_q;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc, opnd;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              neg_q, neg_d;

  assign ir_op  = op_e'(ir_q[DATA_W-1 -: OP_W]);
  assign opnd   = ir_q[ADDR_W-1:0];
  assign pc_inc = pc_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= mem_rdata;
  end

  always_comb begin
    pc_d  = pc_q;
    acc_d = acc_q;
    neg_d = neg_q;
    push  = 1'b0;
    pop   = 1'b0;
    if (wb_phase) begin
      unique case (ir_op)
        OP_CALL: begin
          push = 1'b1;
          pc_d = opnd;
        end
        OP_RET: begin
          pop  = 1'b1;
          pc_d = pop_addr;
        end
        OP_ADD: begin
          acc_d = acc_q + mem_rdata;
          neg_d = acc_d[DATA_W-1];
          pc_d  = pc_inc;
        end
        OP_LOAD: begin
          acc_d = mem_rdata;
          neg_d = mem_rdata[DATA_W-1];
          pc_d  = pc_inc;
        end
        OP_BRN:  pc_d = neg_q ? opnd : pc_inc;
        OP_STOP: pc_d = pc_q;
        default: pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      acc_q <= '0;
      neg_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      acc_q <= acc_d;
      neg_q <= neg_d;
    end
  end

  assign push_addr = pc_inc;
  assign mem_addr  = mem_phase ? opnd : pc_q;
  assign mem_we    = mem_phase && (ir_op == OP_STORE);
  assign mem_wdata = acc_q;
  assign pc        = pc_q;
  assign acc       = acc_q;
  assign neg       = neg_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int STK_DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_we,
  output logic [ADDR_W+OP_W-1:0]  mem_wdata,
  input  logic [ADDR_W+OP_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]       pc_o,
  output logic [ADDR_W+OP_W-1:0]  acc_o,
  output logic                    neg_o,
  output logic                    halted_o
);
  localparam int DATA_W = ADDR_W + OP_W;

  logic              ir_en, mem_phase, wb_phase;
  logic              push, pop;
  logic [ADDR_W-1:0] push_addr, pop_addr;
  op_e               ir_op, dec_op;

  assign dec_op = op_e'(mem_rdata[DATA_W-1 -: OP_W]);

  acc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_op    (dec_op),
    .ir_op     (ir_op),
    .ir_en     (ir_en),
    .mem_phase (mem_phase),
    .wb_phase  (wb_phase),
    .halted    (halted_o)
  );

  acc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_en     (ir_en),
    .mem_phase (mem_phase),
    .wb_phase  (wb_phase),
    .mem_rdata (mem_rdata),
    .pop_addr  (pop_addr),
    .push      (push),
    .pop       (pop),
    .push_addr (push_addr),
    .ir_op     (ir_op),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .pc        (pc_o),
    .acc       (acc_o),
    .neg       (neg_o)
  );

  acc_rstack #(.DEPTH(STK_DEPTH), .W(ADDR_W)) u_rstack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .push_data (push_addr),
    .pop_data  (pop_addr)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] pc_o,
  input logic [DATA_W-1:0] acc_o,
  input logic              neg_o,
  input logic              halted_o,
  input logic              in_wb,
  input logic [OP_W-1:0]   wb_op
);
  p_pc_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_o) |-> $past(in_wb));

  p_acc_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_o) |-> $past(in_wb));

  p_flag_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_o) |-> (neg_o == acc_o[DATA_W-1]));

  p_flag_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(neg_o) |-> ($past(in_wb) &&
      ($past(wb_op) == OP_ADD || $past(wb_op) == OP_LOAD)));

  p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == acc_o));

  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> (halted_o && $stable(pc_o) && $stable(acc_o)));

  p_halt_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !mem_we);
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(ADDR_W + acc_pkg::OP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .pc_o      (pc_o),
  .acc_o     (acc_o),
  .neg_o     (neg_o),
  .halted_o  (halted_o),
  .in_wb     (wb_phase),
  .wb_op     (ir_op)
);

// File: tb/test_acc_core.sv
module test_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] mem_addr;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [12:0] pc_o;
  logic [15:0] acc_o;
  logic        neg_o;
  logic        halted_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_core i_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_o(pc_o),
    .acc_o(acc_o), .neg_o(neg_o), .halted_o(halted_o)
  );

  // 64-word RAM model; addresses alias on their low six bits (0x1FFF -> 63)
  logic [15:0] ram [64];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[5:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[5:0]];
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_ram();
    for (int i = 0; i < 64; i++) ram[i] = 16'hC000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_to_halt(output int cyc);
    cyc = 0;
    while (cyc < 500) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (halted_o) break;
    end
  endtask

  // Vector: slot 0 = Load 0x10 (operand a), slot 1 = instruction under test
  // with operand 0x11 (b), slot 2 = Stop, slot 8 = Stop (branch target)
  typedef struct packed {
    logic [15:0] ins;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp_acc;
    logic        exp_neg;
    logic [12:0] exp_pc;
    logic [15:0] exp_m;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{16'h8011, 16'h0005, 16'h1234, 16'h1234, 1'b0, 13'h002, 16'h1234}, // R2 R3 load positive
    '{16'h8011, 16'h0005, 16'hF000, 16'hF000, 1'b1, 13'h002, 16'hF000}, // R3 load negative
    '{16'h4011, 16'h000A, 16'h0014, 16'h001E, 1'b0, 13'h002, 16'h0014}, // R4 add
    '{16'h4011, 16'hFFFF, 16'h0002, 16'h0001, 1'b0, 13'h002, 16'h0002}, // R4 wrap mod 2^16
    '{16'h4011, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 13'h002, 16'h0001}, // R4 sum goes negative
    '{16'hA011, 16'h8001, 16'h0000, 16'h8001, 1'b1, 13'h002, 16'h8001}, // R5 R9 store keeps flag
    '{16'h6008, 16'h9000, 16'h1111, 16'h9000, 1'b1, 13'h008, 16'h1111}, // R6 branch taken
    '{16'h6008, 16'h0001, 16'h1111, 16'h0001, 1'b0, 13'h002, 16'h1111}, // R6 R9 branch not taken
    '{16'hC000, 16'h0033, 16'h2222, 16'h0033, 1'b0, 13'h001, 16'h2222}  // R8 stop holds pc
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int cyc;
    int we_seen;
    logic [12:0] pc_hold;
    logic [15:0] acc_hold;

    // R1 reset state
    clear_ram();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 pc", 32'(pc_o), 0);
    check("R1 acc", 32'(acc_o), 0);
    check("R1 neg", 32'(neg_o), 0);
    check("R1 halted", 32'(halted_o), 0);
    check("R1 fetch addr", 32'(mem_addr), 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      clear_ram();
      ram[0]  = 16'h8010;
      ram[1]  = VT[v].ins;
      ram[16] = VT[v].a;
      ram[17] = VT[v].b;
      do_reset();
      run_to_halt(cyc);
      check($sformatf("vec%0d acc", v), 32'(acc_o), 32'(VT[v].exp_acc));
      check($sformatf("vec%0d neg", v), 32'(neg_o), 32'(VT[v].exp_neg));
      check($sformatf("vec%0d pc", v), 32'(pc_o), 32'(VT[v].exp_pc));
      check($sformatf("vec%0d mem", v), 32'(ram[17]), 32'(VT[v].exp_m));
    end

    // R10 timing: load, add, stop = 4 + 4 + 3 cycles
    clear_ram();
    ram[0] = 16'h8003; ram[1] = 16'h4004; ram[2] = 16'hC000;
    ram[3] = 16'd10;   ram[4] = 16'd20;
    do_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 acc before commit", 32'(acc_o), 0);
    check("R10 pc before commit", 32'(pc_o), 0);
    @(posedge clk); @(negedge clk);
    check("R10 acc at cycle 4", 32'(acc_o), 10);
    check("R10 pc at cycle 4", 32'(pc_o), 1);
    run_to_halt(cyc);
    check("R10 cycles to halt", 32'(cyc + 4), 11);
    check("R4 program result", 32'(acc_o), 30);
    check("R4 program flag", 32'(neg_o), 0);

    // R8 frozen after halt
    pc_hold = pc_o; acc_hold = acc_o; we_seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mem_we) we_seen++;
    end
    check("R8 pc frozen", 32'(pc_o), 32'(pc_hold));
    check("R8 acc frozen", 32'(acc_o), 32'(acc_hold));
    check("R8 no writes", 32'(we_seen), 0);
    check("R8 still halted", 32'(halted_o), 1);

    // R7 nested call and return
    clear_ram();
    ram[0]  = 16'h0010;  // call 0x10
    ram[1]  = 16'hC000;
    ram[16] = 16'h0020;  // call 0x20
    ram[17] = 16'h4031;  // add 0x31
    ram[18] = 16'h2000;  // return
    ram[32] = 16'h8030;  // load 0x30
    ram[33] = 16'h2000;  // return
    ram[48] = 16'h0042;
    ram[49] = 16'h0001;
    do_reset();
    run_to_halt(cyc);
    check("R7 acc after nested calls", 32'(acc_o), 32'h43);
    check("R7 pc returns to caller", 32'(pc_o), 1);
    check("R7 halted", 32'(halted_o), 1);

    // R11 PC wraps from 0x1FFF to 0
    clear_ram();
    ram[0]  = 16'h8005;  // load 0x8000 -> flag set
    ram[1]  = 16'h7FFF;  // brn 0x1FFF
    ram[5]  = 16'h8000;
    ram[6]  = 16'h0007;
    ram[63] = 16'h8006;  // word at 0x1FFF: load 6
    do_reset();
    cyc = 0;
    while (pc_o != 13'h1FFF && cyc < 200) begin @(negedge clk); cyc++; end
    check("R6 branch to top", 32'(pc_o), 32'h1FFF);
    while (pc_o == 13'h1FFF && cyc < 400) begin @(negedge clk); cyc++; end
    check("R11 pc wraps", 32'(pc_o), 0);
    check("R11 load at top", 32'(acc_o), 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule